// File: doc/BRIEF.md
# Flag-Tracked Register Stack

A last-in first-out store of 64 words held in flip-flops. A pointer register always addresses the item currently on top of the stack. A push moves the pointer up first and then stores the incoming word at the new address. A pop copies the word at the current address into a read-data register and then moves the pointer down.

The pointer wraps modulo the depth, so it reads zero both when nothing is stored and when all 64 locations are used. Two status flags, full and empty, are the only state that tells those two cases apart. Every location, address 0 included, holds data.

Requests that cannot be served change nothing and raise a one-cycle error pulse. These are a push while full, a pop while empty, and a push and a pop in the same cycle.

Top module: `reg_stack`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, the pointer is 0, empty is 1, full is 0, the error output is 0 and the read data is 0.
- R2: An accepted push raises the pointer by one (wrapping 63 to 0) and stores the write data at the new pointer value.
- R3: An accepted push whose incremented pointer equals 0 sets full, so 64 pushes from an empty stack fill it. Full and empty are never 1 together.
- R4: Every accepted push clears empty.
- R5: An accepted pop loads the read-data register with the word at the current pointer and then lowers the pointer by one (wrapping 0 to 63), so words come back in reverse order of their pushes.
- R6: An accepted pop whose decremented pointer equals 0 sets empty.
- R7: Every accepted pop clears full.
- R8: A push while full is ignored: pointer, flags and stored words keep their values, and the error output is 1 for the following cycle only.
- R9: A pop while empty is ignored: pointer, flags and read data keep their values, and the error output is 1 for the following cycle.
- R10: A push and a pop requested in the same cycle are both ignored and the error output is 1 for the following cycle.
- R11: After a cycle with no request or an accepted request, the error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| wdata_i | input | W (8) | Word to store on a push |
| rdata_o | output | W (8) | Read-data register, loaded by an accepted pop |
| full_o | output | 1 | All locations hold data |
| empty_o | output | 1 | No location holds data |
| err_o | output | 1 | One-cycle pulse after a rejected request |
| sp_o | output | AW (6) | Stack pointer, addresses the top item |

## Verification
The bench fills the stack completely so the pointer wraps back to zero. A design that tested the flag condition on the old pointer, or that wrote before incrementing, would flag full one push early or lose the word at address 0, and the pops that follow would return a wrong word. It pushes into a full stack and pops from an empty one, then drains or refills the stack. A design that moved the pointer or overwrote data on a rejected request would return a shifted sequence or corrupt read data. Same-cycle push and pop, mixed push/pop runs and a full-to-not-full transition catch flags that are cleared on the wrong operation.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } stk_op_e;

  // Pointer arithmetic modulo the depth, one step up or down.
  function automatic int unsigned ptr_step(input int unsigned p, input bit up,
                                           input int unsigned depth);
    if (up) return (p + 1) % depth;
    return (p + depth - 1) % depth;
  endfunction

  // Decide what a request does given the present flags.
  function automatic stk_op_e classify(input logic push, input logic pop,
                                       input logic full, input logic empty);
    if (push && pop) return OP_REJECT;
    if (push)        return full ? OP_REJECT : OP_PUSH;
    if (pop)         return empty ? OP_REJECT : OP_POP;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op,
  output logic    err
);

  assign op = classify(push_req, pop_req, full, empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= (op == OP_REJECT);
  end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up,
  output logic          full,
  output logic          empty
);

  logic [AW-1:0] sp_dn;

  assign sp_up = AW'(ptr_step(32'(sp), 1'b1, DEPTH));
  assign sp_dn = AW'(ptr_step(32'(sp), 1'b0, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      case (op)
        OP_PUSH: begin
          sp    <= sp_up;
          empty <= 1'b0;
          if (sp_up == '0) full <= 1'b1;
        end
        OP_POP: begin
          sp   <= sp_dn;
          full <= 1'b0;
          if (sp_dn == '0) empty <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ent[i] <= '0;
      else if (we && waddr == AW'(i))    ent[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= ent[raddr];
  end

endmodule

// File: rtl/reg_stack.sv
module reg_stack
  import stk_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o,
  output logic [AW-1:0] sp_o
);

  stk_op_e       op;
  logic [AW-1:0] sp_up;
  logic          ev_push;
  logic          ev_pop;

  assign ev_push = (op == OP_PUSH);
  assign ev_pop  = (op == OP_POP);

  stk_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_i),
    .pop_req  (pop_i),
    .full     (full_o),
    .empty    (empty_o),
    .op       (op),
    .err      (err_o)
  );

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .sp    (sp_o),
    .sp_up (sp_up),
    .full  (full_o),
    .empty (empty_o)
  );

  stk_regfile #(.DEPTH(DEPTH), .W(W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_push),
    .waddr (sp_up),
    .wdata (wdata_i),
    .re    (ev_pop),
    .raddr (sp_o),
    .rdata (rdata_o)
  );

endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int AW = 6,
  parameter int W  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          err_o,
  input logic [AW-1:0] sp_o,
  input logic [W-1:0]  rdata_o,
  input logic          ev_push,
  input logic          ev_pop
);

  logic push_ok, pop_ok;
  assign push_ok = push_i && !pop_i && !full_o;
  assign pop_ok  = pop_i && !push_i && !empty_o;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (sp_o == '0) && empty_o && !full_o); // R1
  AST_PUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp_o == AW'($past(sp_o) + 1'b1)); // R2
  AST_PUSH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> ev_push && !ev_pop); // R2
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && sp_o == '1) |=> full_o); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o)); // R3
  AST_PUSH_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !empty_o); // R4
  AST_POP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> sp_o == AW'($past(sp_o) - 1'b1)); // R5
  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && sp_o == AW'(1)) |=> empty_o); // R6
  AST_POP_CLR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !full_o); // R7
  AST_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp_o)); // R8
  AST_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> err_o && empty_o && $stable(sp_o) && $stable(rdata_o)); // R9
  AST_BOTH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> err_o && $stable(sp_o) && $stable(full_o) && $stable(empty_o)); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok || pop_ok || (!push_i && !pop_i)) |=> !err_o); // R11

endmodule

bind reg_stack stk_chk #(.AW(AW), .W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .full_o  (full_o),
  .empty_o (empty_o),
  .err_o   (err_o),
  .sp_o    (sp_o),
  .rdata_o (rdata_o),
  .ev_push (ev_push),
  .ev_pop  (ev_pop)
);

// File: tb/tb_reg_stack.sv
module tb_reg_stack;

  localparam int DEPTH = 64;
  localparam int W     = 8;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [W-1:0]  wdata_i = '0;
  logic [W-1:0]  rdata_o;
  logic          full_o, empty_o, err_o;
  logic [AW-1:0] sp_o;

  reg_stack #(.DEPTH(DEPTH), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .full_o(full_o),
    .empty_o(empty_o), .err_o(err_o), .sp_o(sp_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit reported = 0;
  logic [W-1:0] mdl [$];
  int           due_q [$];
  logic [W-1:0] val_q [$];
  logic [W-1:0] last_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compares popped words against the scoreboard once they are due.
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] <= cyc) begin
      chk("R2 R5", "rdata", rdata_o, val_q[0]);
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end
  end

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic op(input logic ps, input logic pp, input logic [W-1:0] d, input string req);
    bit bad;
    int n;
    #1;
    push_i = ps; pop_i = pp; wdata_i = d;
    bad = (ps && pp) || (ps && mdl.size() == DEPTH) || (pp && mdl.size() == 0);
    if (!bad && ps) mdl.push_back(d);
    if (!bad && pp) begin
      due_q.push_back(cyc + 1);
      val_q.push_back(mdl[$]);
      last_rd = mdl[$];
      void'(mdl.pop_back());
    end
    @(posedge clk);
    #1;
    push_i = 1'b0; pop_i = 1'b0;
    @(negedge clk);
    n = mdl.size();
    chk(req, "err", err_o, (ps || pp) && bad);
    chk(req, "sp", sp_o, n % DEPTH);
    chk(req, "full", full_o, n == DEPTH);
    chk(req, "empty", empty_o, n == 0);
  endtask

  initial begin
    #(20 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "sp in reset", sp_o, 0);
    chk("R1", "empty in reset", empty_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sp", sp_o, 0);
    chk("R1", "empty", empty_o, 1);
    chk("R1", "full", full_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "rdata", rdata_o, 0);

    // Pop on empty stack: ignored, read data held.
    op(1'b0, 1'b1, '0, "R9");
    chk("R9", "rdata held", rdata_o, last_rd);
    op(1'b0, 1'b0, '0, "R11");

    // Small LIFO run.
    for (int i = 0; i < 5; i++) op(1'b1, 1'b0, W'(i * 37 + 5), "R4");
    op(1'b0, 1'b1, '0, "R5");
    op(1'b0, 1'b1, '0, "R5");
    for (int i = 0; i < 3; i++) op(1'b1, 1'b0, W'(200 - i * 11), "R2");

    // Simultaneous push and pop.
    op(1'b1, 1'b1, 8'hEE, "R10");
    op(1'b0, 1'b0, '0, "R11");

    // Alternating traffic.
    for (int i = 0; i < 4; i++) begin
      op(1'b1, 1'b0, W'(i * 3 + 90), "R2");
      op(1'b0, 1'b1, '0, "R5");
    end

    // Drain to empty.
    while (mdl.size() > 0) op(1'b0, 1'b1, '0, "R6");
    op(1'b0, 1'b1, '0, "R9");
    chk("R9", "rdata held", rdata_o, last_rd);

    // Fill all locations, pointer wraps to 0.
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, W'(i * 7 + 1), "R3");
    op(1'b1, 1'b0, 8'h55, "R8");
    op(1'b0, 1'b0, '0, "R11");
    op(1'b1, 1'b1, 8'h66, "R10");
    op(1'b0, 1'b1, '0, "R7");
    op(1'b1, 1'b0, 8'hA5, "R3");

    // Drain everything: checks every stored word, address 0 included.
    while (mdl.size() > 0) op(1'b0, 1'b1, '0, "R6");
    op(1'b0, 1'b0, '0, "R11");
    @(negedge clk);
    chk("R5", "scoreboard drained", due_q.size(), 0);
    report();
  end

endmodule